// File: doc/BRIEF.md
# Memory-operand effective address generator

This block turns a decoded x86 memory-operand description into a linear effective address. The inputs are the ModR/M byte, an optional SIB byte, a displacement, the instruction length and the current instruction pointer. Register values come from a flat vector that holds all sixteen general registers side by side. The two REX extension bits for base and index arrive as separate inputs. A start strobe launches one computation. One clock later the address appears with a valid pulse. If the ModR/M byte names a register operand instead of memory, an error pulse appears in its place.

Four addressing modes are supported: 16-bit, 32-bit, 64-bit, and 32-bit addressing inside 64-bit mode. The address is computed before any segment base is added and before any limit or canonical check. Those steps, and the memory access itself, belong to the stages that follow this block.

Top module: `mem_ea_gen`

## Requirements
- R1: `ea_valid` or `ea_err` pulses high for exactly one cycle, in the cycle after the clock edge that samples `start` high, and both stay low otherwise. `ea` only changes in response to a `start`.
- R2: With `mode`=00 (16-bit), the rm field values 0..7 select these base sums: BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP, BX. The register slots are BX=3, BP=5, SI=6, DI=7, using the low 16 bits of each slot. The sum wraps modulo 2^16 and is zero-extended to 64 bits.
- R3: With `mode`=00, mod=00 together with rm=110 yields the 16-bit displacement `disp[15:0]` alone, with no register added.
- R4: mod=00 adds no displacement. mod=01 adds `disp[7:0]` sign-extended. mod=10 adds the full displacement: `disp[15:0]` in 16-bit mode, and `disp[31:0]` sign-extended otherwise.
- R5: With `mode`=01 (32-bit), mod=00 with rm=101 yields `disp` alone, and rm=100 selects the SIB form. The result wraps modulo 2^32 and is zero-extended. `rex_b` and `rex_x` have no effect in this mode.
- R6: In the SIB form, the index register (sib[5:3]) is shifted left by the scale field (sib[7:6]), and then the base register (sib[2:0]) is added. An index number of 0100 (REX.X clear, field 100) contributes zero.
- R7: In the SIB form, a base field of 101 adds register 5, or register 13 with REX.B, when mod is nonzero. When mod=00 it adds the sign-extended 32-bit displacement instead.
- R8: With `mode`=10 (64-bit), mod=00 with rm=101 yields `ip + ilen + sext(disp)`, whatever the value of `rex_b`.
- R9: In modes 10 and 11, `rex_b` forms bit 3 of the rm and base register numbers, and `rex_x` forms bit 3 of the index number. An extended rm of 1100 also selects the SIB form. An extended index of 1100 selects register 12.
- R10: With `mode`=11 (32-bit inside 64-bit mode), the full 64-bit computation is performed, RIP-relative form included, and the result is truncated to its low 32 bits.
- R11: mod=11 is rejected. The block pulses `ea_err`, keeps `ea_valid` low and loads `ea` with zero.
- R12: Under reset, `ea`, `ea_valid` and `ea_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches one address computation |
| mode | input | 2 | 00 16-bit, 01 32-bit, 10 64-bit, 11 32-bit inside 64-bit mode |
| modrm | input | 8 | ModR/M byte: mod [7:6], reg [5:3] (unused), rm [2:0] |
| sib | input | 8 | SIB byte: scale [7:6], index [5:3], base [2:0] |
| rex_b | input | 1 | Extension bit 3 of the rm and base register numbers |
| rex_x | input | 1 | Extension bit 3 of the index register number |
| disp | input | 32 | Displacement, right-aligned |
| ilen | input | 4 | Length of the instruction in bytes |
| ip | input | 64 | Address of the current instruction |
| gpr_flat | input | 1024 | Sixteen 64-bit registers; slot n at bits [64n+63:64n] |
| ea | output | 64 | Effective address, zero-extended |
| ea_valid | output | 1 | One-cycle pulse: `ea` holds a memory address |
| ea_err | output | 1 | One-cycle pulse: the operand was a register form |

## Verification
The assertions check the timing on every cycle: each valid or error pulse follows a start, the result holds still between starts, and an error carries a zero address. They also check the result width, so 16-bit and 32-bit results never carry upper bits, along with the direct 16-bit displacement form and the rule that RIP-relative addressing happens only in the long modes. The actual sums can only be shown by the bench's scenarios. These cover each entry of the register-pair table, the scale and index combinations, the base-101 rule, REX extension to registers 12 and 13, RIP-relative addressing, and truncation and wrap-around. They are compared against an independent reference model.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [1:0] {
    AM_16       = 2'd0,
    AM_32       = 2'd1,
    AM_64       = 2'd2,
    AM_32_IN_64 = 2'd3
  } addr_mode_e;

  localparam int unsigned EA_W    = 64;
  localparam int unsigned DISP_W  = 32;
  localparam int unsigned SLOT_BX = 3;
  localparam int unsigned SLOT_BP = 5;
  localparam int unsigned SLOT_SI = 6;
  localparam int unsigned SLOT_DI = 7;

  function automatic logic [EA_W-1:0] sx8(input logic [7:0] v);
    return {{(EA_W-8){v[7]}}, v};
  endfunction

  function automatic logic [EA_W-1:0] sx32(input logic [DISP_W-1:0] v);
    return {{(EA_W-DISP_W){v[DISP_W-1]}}, v};
  endfunction

  // Displacement term for the 32/64-bit paths, chosen by the mod field.
  function automatic logic [EA_W-1:0] disp_term(input logic [1:0] md, input logic [DISP_W-1:0] d);
    case (md)
      2'd1:    return sx8(d[7:0]);
      2'd2:    return sx32(d);
      default: return '0;
    endcase
  endfunction

  // Displacement term for the 16-bit path.
  function automatic logic [15:0] disp_term16(input logic [1:0] md, input logic [15:0] d);
    case (md)
      2'd1:    return {{8{d[7]}}, d[7:0]};
      2'd2:    return d;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/ea_pair16.sv
module ea_pair16 import ea_pkg::*; #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned NREG = 16
) (
  input  logic [NREG*XLEN-1:0] gpr_flat,
  input  logic [7:0]           modrm,
  input  logic [15:0]          disp16,
  output logic [15:0]          sum16,
  output logic                 direct16
);
  localparam int unsigned HW = 16;

  logic [HW-1:0] r_bx, r_bp, r_si, r_di;
  logic [HW-1:0] pair;

  assign r_bx = gpr_flat[SLOT_BX*XLEN +: HW];
  assign r_bp = gpr_flat[SLOT_BP*XLEN +: HW];
  assign r_si = gpr_flat[SLOT_SI*XLEN +: HW];
  assign r_di = gpr_flat[SLOT_DI*XLEN +: HW];

  always_comb begin
    direct16 = (modrm[7:6] == 2'd0) && (modrm[2:0] == 3'd6);
    case (modrm[2:0])
      3'd0:    pair = r_bx + r_si;
      3'd1:    pair = r_bx + r_di;
      3'd2:    pair = r_bp + r_si;
      3'd3:    pair = r_bp + r_di;
      3'd4:    pair = r_si;
      3'd5:    pair = r_di;
      3'd6:    pair = r_bp;
      default: pair = r_bx;
    endcase
    sum16 = direct16 ? disp16 : pair + disp_term16(modrm[7:6], disp16);
  end

endmodule

// File: rtl/ea_wide.sv
module ea_wide import ea_pkg::*; #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned NREG   = 16,
  parameter int unsigned ILEN_W = 4
) (
  input  logic [NREG*XLEN-1:0] gpr_flat,
  input  logic [7:0]           modrm,
  input  logic [7:0]           sib,
  input  logic                 ext_b,
  input  logic                 ext_x,
  input  logic                 long_mode,
  input  logic [DISP_W-1:0]    disp,
  input  logic [ILEN_W-1:0]    ilen,
  input  logic [XLEN-1:0]      ip,
  output logic [XLEN-1:0]      sum,
  output logic                 rip_rel,
  output logic                 sib_used,
  output logic                 no_index
);
  localparam int unsigned RN_W = $clog2(NREG);

  logic [XLEN-1:0] gpr [NREG];

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_slot
      assign gpr[g] = gpr_flat[g*XLEN +: XLEN];
    end
  endgenerate

  logic [RN_W-1:0] rm_n, idx_n, base_n;
  logic            disp_only, base_is_disp;
  logic [XLEN-1:0] scaled, base_val, core;

  assign rm_n   = RN_W'({ext_b, modrm[2:0]});
  assign idx_n  = RN_W'({ext_x, sib[5:3]});
  assign base_n = RN_W'({ext_b, sib[2:0]});

  always_comb begin
    disp_only    = (modrm[7:6] == 2'd0) && (modrm[2:0] == 3'd5);
    rip_rel      = disp_only && long_mode;
    sib_used     = (modrm[2:0] == 3'd4);
    no_index     = ({ext_x, sib[5:3]} == 4'b0100);
    base_is_disp = (sib[2:0] == 3'd5) && (modrm[7:6] == 2'd0);

    scaled   = (no_index ? '0 : gpr[idx_n]) << sib[7:6];
    base_val = base_is_disp ? sx32(disp) : gpr[base_n];

    if (rip_rel)       core = ip + XLEN'(ilen);
    else if (disp_only) core = '0;
    else if (sib_used)  core = scaled + base_val;
    else                core = gpr[rm_n];

    sum = core + (disp_only ? sx32(disp) : disp_term(modrm[7:6], disp));
  end

endmodule

// File: rtl/ea_out_stage.sv
module ea_out_stage #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            reg_form,
  input  logic [XLEN-1:0] ea_next,
  output logic [XLEN-1:0] ea,
  output logic            ea_valid,
  output logic            ea_err
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea       <= '0;
      ea_valid <= 1'b0;
      ea_err   <= 1'b0;
    end else begin
      ea_valid <= start && !reg_form;
      ea_err   <= start && reg_form;
      if (start) ea <= reg_form ? '0 : ea_next;
    end
  end

endmodule

// File: rtl/mem_ea_gen.sv
module mem_ea_gen import ea_pkg::*; #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned NREG   = 16,
  parameter int unsigned ILEN_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           mode,
  input  logic [7:0]           modrm,
  input  logic [7:0]           sib,
  input  logic                 rex_b,
  input  logic                 rex_x,
  input  logic [31:0]          disp,
  input  logic [ILEN_W-1:0]    ilen,
  input  logic [XLEN-1:0]      ip,
  input  logic [NREG*XLEN-1:0] gpr_flat,
  output logic [XLEN-1:0]      ea,
  output logic                 ea_valid,
  output logic                 ea_err
);
  localparam int unsigned NARROW = 32;
  localparam int unsigned HW     = 16;

  addr_mode_e      am;
  logic            long_mode;
  logic            reg_form;
  logic            direct16;
  logic            rip_rel, sib_used, no_index;
  logic [HW-1:0]   sum16;
  logic [XLEN-1:0] sum_wide;
  logic [XLEN-1:0] ea_next;

  assign am        = addr_mode_e'(mode);
  assign long_mode = (am == AM_64) || (am == AM_32_IN_64);
  assign reg_form  = (modrm[7:6] == 2'b11);

  ea_pair16 #(.XLEN(XLEN), .NREG(NREG)) u_pair16 (
    .gpr_flat (gpr_flat),
    .modrm    (modrm),
    .disp16   (disp[HW-1:0]),
    .sum16    (sum16),
    .direct16 (direct16)
  );

  ea_wide #(.XLEN(XLEN), .NREG(NREG), .ILEN_W(ILEN_W)) u_wide (
    .gpr_flat  (gpr_flat),
    .modrm     (modrm),
    .sib       (sib),
    .ext_b     (rex_b && long_mode),
    .ext_x     (rex_x && long_mode),
    .long_mode (long_mode),
    .disp      (disp),
    .ilen      (ilen),
    .ip        (ip),
    .sum       (sum_wide),
    .rip_rel   (rip_rel),
    .sib_used  (sib_used),
    .no_index  (no_index)
  );

  always_comb begin
    case (am)
      AM_16:   ea_next = XLEN'(sum16);
      AM_64:   ea_next = sum_wide;
      default: ea_next = XLEN'(sum_wide[NARROW-1:0]);
    endcase
  end

  ea_out_stage #(.XLEN(XLEN)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .reg_form (reg_form),
    .ea_next  (ea_next),
    .ea       (ea),
    .ea_valid (ea_valid),
    .ea_err   (ea_err)
  );

endmodule

// File: rtl/mem_ea_gen_chk.sv
module mem_ea_gen_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [1:0]      mode,
  input logic [7:0]      modrm,
  input logic [31:0]     disp,
  input logic [XLEN-1:0] ea,
  input logic            ea_valid,
  input logic            ea_err,
  input logic            rip_rel,
  input logic            sib_used,
  input logic            direct16
);

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid |-> $past(start)); // R1
  AST_MEM_FORM_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start) && $past(modrm[7:6]) != 2'b11) |-> ea_valid); // R1
  AST_QUIET_WITHOUT_START: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(start) |-> (!ea_valid && !ea_err && $stable(ea))); // R1
  AST_ERR_ON_REG_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    ea_err |-> ($past(start) && $past(modrm[7:6]) == 2'b11 && ea == '0)); // R11
  AST_ADDR16_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && $past(mode) == 2'd0) |-> (ea[XLEN-1:16] == '0)); // R2
  AST_DIRECT16_DISP: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && $past(mode) == 2'd0 && $past(direct16)) |-> (ea == XLEN'($past(disp[15:0])))); // R3
  AST_ADDR32_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && $past(mode[0])) |-> (ea[XLEN-1:32] == '0)); // R10
  AST_RIPREL_LONG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rip_rel |-> (mode[1] && !sib_used)); // R8

endmodule

bind mem_ea_gen mem_ea_gen_chk #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .mode     (mode),
  .modrm    (modrm),
  .disp     (disp),
  .ea       (ea),
  .ea_valid (ea_valid),
  .ea_err   (ea_err),
  .rip_rel  (rip_rel),
  .sib_used (sib_used),
  .direct16 (direct16)
);

// File: tb/test_mem_ea_gen.sv
`timescale 1ns/1ps
module test_mem_ea_gen;
  localparam int XL = 64;
  localparam int NR = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [1:0]      mode = '0;
  logic [7:0]      modrm = '0, sib = '0;
  logic            rex_b = 1'b0, rex_x = 1'b0;
  logic [31:0]     disp = '0;
  logic [3:0]      ilen = '0;
  logic [XL-1:0]   ip = '0;
  logic [NR*XL-1:0] gpr_flat = '0;
  logic [XL-1:0]   ea;
  logic            ea_valid, ea_err;

  logic [XL-1:0] regs [NR];
  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mem_ea_gen i_mem_ea_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .modrm(modrm), .sib(sib),
    .rex_b(rex_b), .rex_x(rex_x), .disp(disp), .ilen(ilen), .ip(ip),
    .gpr_flat(gpr_flat), .ea(ea), .ea_valid(ea_valid), .ea_err(ea_err)
  );

  task automatic chk(input string tag, input logic [XL-1:0] act, input logic [XL-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_regs();
    for (int i = 0; i < NR; i++) gpr_flat[i*XL +: XL] = regs[i];
  endtask

  // Independent reference model.
  function automatic logic [XL-1:0] ref_ea(input int md, input logic [7:0] m, input logic [7:0] s,
                                           input bit rb, input bit rx, input logic [31:0] d,
                                           input logic [3:0] il, input logic [XL-1:0] ipv);
    int mo = int'(m[7:6]);
    int rm = int'(m[2:0]);
    logic signed [XL-1:0] d8, d32;
    logic [XL-1:0] a;
    logic [15:0] h;
    bit lng = (md >= 2);
    int ex_b = (lng && rb) ? 8 : 0;
    int ex_x = (lng && rx) ? 8 : 0;
    d8  = $signed(d[7:0]);
    d32 = $signed(d);
    if (md == 0) begin
      if (mo == 0 && rm == 6) return XL'(d[15:0]);
      case (rm)
        0: h = regs[3][15:0] + regs[6][15:0];
        1: h = regs[3][15:0] + regs[7][15:0];
        2: h = regs[5][15:0] + regs[6][15:0];
        3: h = regs[5][15:0] + regs[7][15:0];
        4: h = regs[6][15:0];
        5: h = regs[7][15:0];
        6: h = regs[5][15:0];
        default: h = regs[3][15:0];
      endcase
      if (mo == 1) h = h + d8[15:0];
      else if (mo == 2) h = h + d[15:0];
      return XL'(h);
    end
    if (mo == 0 && rm == 5) begin
      a = lng ? (ipv + XL'(il) + d32) : d32;
    end else begin
      if (rm == 4) begin
        int idx = int'(s[5:3]) + ex_x;
        int bse = int'(s[2:0]) + ex_b;
        a = (idx == 4) ? '0 : regs[idx];
        a = a << s[7:6];
        if (s[2:0] == 3'd5 && mo == 0) a = a + d32;
        else a = a + regs[bse];
      end else begin
        a = regs[rm + ex_b];
      end
      if (mo == 1) a = a + d8;
      else if (mo == 2) a = a + d32;
    end
    if (md == 1 || md == 3) a = {32'b0, a[31:0]};
    return a;
  endfunction

  task automatic issue(input int md, input logic [7:0] m, input logic [7:0] s, input bit rb, input bit rx,
                       input logic [31:0] d, input logic [3:0] il, input logic [XL-1:0] ipv, input string tag);
    logic [XL-1:0] exp;
    bit reg_form = (m[7:6] == 2'b11);
    exp = reg_form ? '0 : ref_ea(md, m, s, rb, rx, d, il, ipv);
    @(negedge clk);
    load_regs();
    mode = 2'(md); modrm = m; sib = s; rex_b = rb; rex_x = rx; disp = d; ilen = il; ip = ipv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " ea"}, ea, exp);
    chk({tag, " flags"}, XL'({ea_valid, ea_err}), XL'({!reg_form, reg_form}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [XL-1:0] held;
    void'($urandom(32'h1234_5eed));
    for (int i = 0; i < NR; i++) regs[i] = {$urandom, $urandom};
    load_regs();
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 reset ea", ea, '0);
    chk("R12 reset flags", XL'({ea_valid, ea_err}), '0);
    rst_n = 1'b1;

    // R2, R4: each 16-bit pair with an 8-bit negative displacement
    for (int r = 0; r < 8; r++) issue(0, {2'b01, 3'b000, 3'(r)}, 8'h00, 0, 0, 32'h0000_00F0, 4'd3, '0, "R2 pair16");
    // R3: direct 16-bit displacement, upper disp bits ignored
    issue(0, 8'b00_000_110, 8'h00, 0, 0, 32'hABCD_1234, 4'd4, '0, "R3 direct16");
    chk("R3 literal", ea, 64'h1234);
    // R2: wrap modulo 2^16
    regs[3] = 64'h7777_0000_0000_FFFF; regs[6] = 64'h0000_0000_0000_0002;
    issue(0, 8'b10_000_000, 8'h00, 0, 0, 32'h0000_0010, 4'd3, '0, "R2 wrap16");
    chk("R2 wrap literal", ea, 64'h0011);

    // R5: 32-bit direct displacement, REX ignored
    issue(1, 8'b00_000_101, 8'h00, 1, 1, 32'hDEAD_BEEF, 4'd6, 64'h1000, "R5 direct32");
    chk("R5 literal", ea, 64'hDEAD_BEEF);
    issue(1, 8'b10_000_011, 8'h00, 1, 0, 32'h8000_0000, 4'd6, '0, "R5 rex ignored");
    // R6: scaled index plus base; index 100 contributes nothing
    issue(1, 8'b00_000_100, 8'b11_001_011, 0, 0, '0, 4'd3, '0, "R6 scale8");
    issue(2, 8'b01_000_100, 8'b10_100_000, 0, 0, 32'h0000_0080, 4'd4, '0, "R6 no index");
    // R7: base 101 with mod 00 and mod 01
    issue(2, 8'b00_000_100, 8'b01_010_101, 0, 0, 32'hFFFF_FF00, 4'd7, '0, "R7 base disp");
    issue(2, 8'b01_000_100, 8'b01_010_101, 1, 0, 32'h0000_0004, 4'd4, '0, "R7 base r13");
    // R8: RIP-relative with REX.B set
    issue(2, 8'b00_000_101, 8'h00, 1, 0, 32'hFFFF_FFF0, 4'd7, 64'h0000_7FFF_0000_0100, "R8 riprel");
    chk("R8 literal", ea, 64'h0000_7FFF_0000_00F7);
    // R9: rm 1100 escapes to SIB; index 1100 selects register 12
    issue(2, 8'b10_000_100, 8'b00_100_001, 1, 1, 32'h0000_1000, 4'd5, '0, "R9 ext sib r12");
    issue(2, 8'b00_000_011, 8'h00, 1, 0, '0, 4'd3, '0, "R9 ext rm r11");
    // R10: 32-bit addressing in long mode, truncated RIP-relative
    issue(3, 8'b00_000_101, 8'h00, 0, 0, 32'h0000_0010, 4'd5, 64'h1234_5678_FFFF_FFF0, "R10 riprel trunc");
    chk("R10 literal", ea, 64'h0000_0000_0000_0005);
    issue(3, 8'b10_000_100, 8'b11_100_010, 1, 1, 32'h7FFF_FFFF, 4'd5, '0, "R10 sib trunc");
    // R11: register form rejected
    issue(2, 8'b11_000_001, 8'h00, 0, 0, 32'h55, 4'd3, '0, "R11 regform");
    // R1: no pulse and held result without start
    held = ea;
    @(negedge clk);
    chk("R1 idle flags", XL'({ea_valid, ea_err}), '0);
    chk("R1 idle hold", ea, held);

    // Random mix over all modes (R2 R4 R5 R6 R7 R8 R9 R10 R11)
    for (int k = 0; k < 800; k++) begin
      logic [7:0] m;
      for (int i = 0; i < NR; i++) regs[i] = {$urandom, $urandom};
      m = 8'($urandom);
      if (m[7:6] == 2'b11 && ($urandom % 4) != 0) m[6] = 1'b0;
      issue(int'($urandom % 4), m, 8'($urandom), 1'($urandom), 1'($urandom), $urandom,
            4'($urandom % 15 + 1), {$urandom, $urandom}, "R4 random");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_fail);
    $finish;
  end

endmodule